// File: doc/BRIEF.md
# Two-Point Calibrated Voltage Converter

This block turns a 12-bit converter sample into a millivolt value. It fits a straight line through two graph points. The millivolt value at each point is fixed for the selected range. The code value at each point is corrected at run time by one byte of a 16-bit calibration word. The block interpolates along that line, truncating toward zero, and forces negative results to zero. It can then rescale the result by a divider ratio, rounding to the nearest integer.

A conversion begins when `start` is pulsed while the block is idle. The block copies every input on that edge, so the caller may change them afterwards. It performs up to two long divisions on a single shared restoring divider, which produces one quotient bit per clock. When it finishes, it presents the result with a one-cycle `done` pulse. The result and `err` then hold until the next completion.

Top module: `cal_volt_conv`

## Requirements
- R1: Each graph point's corrected code is (cal byte + nominal code − 128) × 4. The calibration word bits [7:0] correct point 0 and bits [15:8] correct point 1.
- R2: With `big_range`=1, the points are 4200 mV and 3600 mV. Their nominal codes are 856 and 733, or 850 and 728 when `alt_table`=1. With `big_range`=0, the points are 1000 mV and 100 mV. Their nominal codes are 833 and 80, or 838 and 84 when `alt_table`=1.
- R3: The interpolated value is (mV0 − mV1) × (raw − code1) / (code0 − code1) + mV1. It uses signed arithmetic, and the quotient is truncated toward zero.
- R4: A negative interpolated value is output as 0.
- R5: With `ratio_en`=1, the output is (v × `ratio_den` + ⌊`ratio_num`/2⌋) / `ratio_num`, which rounds to the nearest integer with halves going up.
- R6: A ratio with equal numerator and denominator, or `ratio_en`=0, outputs the interpolated value unchanged.
- R7: If code0 equals code1, the output is 0 and `err`=1.
- R8: If `ratio_en`=1 and `ratio_num`=0, the output is 0 and `err`=1.
- R9: `done` is high for exactly one cycle per conversion. `volt_mv` and `err` change only in that cycle and hold until the next completion.
- R10: A `start` pulse that arrives during a conversion is ignored. It produces no extra `done`, and the running result is unaffected.
- R11: After reset, `volt_mv`=0, `done`=0 and `err`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin a conversion when idle |
| raw_code | input | CODE_W | Raw converter sample |
| big_range | input | 1 | 1 selects the high-voltage graph |
| alt_table | input | 1 | 1 selects the alternate nominal code table |
| cal_word | input | 16 | Calibration bytes: [7:0] point 0, [15:8] point 1 |
| ratio_en | input | 1 | Apply the divider ratio after interpolation |
| ratio_num | input | RATIO_W | Ratio numerator (divisor of the rescale) |
| ratio_den | input | RATIO_W | Ratio denominator (multiplier of the rescale) |
| volt_mv | output | PROD_W | Result in millivolts |
| done | output | 1 | One-cycle completion strobe |
| err | output | 1 | Result forced to 0 by a zero divisor |

## Verification
The sweep covers both ranges, both code tables and a set of calibration words. Some of these words make code0 smaller than code1. One of them makes the two codes equal. A design that mishandled the sign of a negative divisor, or that rounded toward minus infinity, would return values off by one or with the wrong sign. A design that skipped the clamp would show huge unsigned results for low codes on the small graph. Directed cases test the following: a rescale that lands exactly on a half, the swap of the calibration bytes, the zero-numerator path, and a second start issued mid-conversion. A design that rounded down, used the wrong byte, divided by zero, or restarted would each give a wrong value or an extra strobe.

// File: rtl/cal_volt_pkg.sv
`timescale 1ns/1ps
// Shared constants, graph tables and state type for the calibrated
// voltage converter. Assumes the two graph points fit in 16 signed bits.
package cal_volt_pkg;
    localparam int PT_W       = 16;
    localparam int CAL_BYTE_W = 8;
    localparam int CAL_W      = 2 * CAL_BYTE_W;
    localparam logic signed [PT_W-1:0] CAL_BIAS = 16'sd128;

    typedef enum logic [1:0] {ST_IDLE, ST_PREP, ST_INTERP, ST_RATIO} conv_state_t;

    // Nominal code of graph point pt (0 or 1) for the range and table
    function automatic logic signed [PT_W-1:0] nominal_code(input logic big, input logic alt, input int pt);
        if (big)
            return (pt == 0) ? (alt ? 16'sd850 : 16'sd856) : (alt ? 16'sd728 : 16'sd733);
        return (pt == 0) ? (alt ? 16'sd838 : 16'sd833) : (alt ? 16'sd84 : 16'sd80);
    endfunction

    // Millivolt value of graph point pt for the range
    function automatic logic signed [PT_W-1:0] graph_mv(input logic big, input int pt);
        if (big)
            return (pt == 0) ? 16'sd4200 : 16'sd3600;
        return (pt == 0) ? 16'sd1000 : 16'sd100;
    endfunction
endpackage

// File: rtl/cal_volt_points.sv
`timescale 1ns/1ps
// Computes the two corrected graph points from the calibration word.
// Purely combinational; assumes inputs are stable registers upstream.
module cal_volt_points
    import cal_volt_pkg::*;
(
    input  logic                   big_range,
    input  logic                   alt_table,
    input  logic [CAL_W-1:0]       cal_word,
    output logic signed [PT_W-1:0] code0,
    output logic signed [PT_W-1:0] code1,
    output logic signed [PT_W-1:0] mv0,
    output logic signed [PT_W-1:0] mv1
);
    logic signed [PT_W-1:0] code_a [2];
    logic signed [PT_W-1:0] mv_a   [2];

    for (genvar p = 0; p < 2; p++) begin : g_pt
        logic signed [PT_W-1:0] byte_s;
        // Zero-extend this point's calibration byte
        assign byte_s = $signed({{(PT_W-CAL_BYTE_W){1'b0}}, cal_word[p*CAL_BYTE_W +: CAL_BYTE_W]});
        // Offset the nominal code and scale by four
        assign code_a[p] = (byte_s + nominal_code(big_range, alt_table, p) - CAL_BIAS) <<< 2;
        assign mv_a[p]   = graph_mv(big_range, p);
    end

    assign code0 = code_a[0];
    assign code1 = code_a[1];
    assign mv0   = mv_a[0];
    assign mv1   = mv_a[1];
endmodule

// File: rtl/cal_volt_udiv.sv
`timescale 1ns/1ps
// Unsigned restoring divider, one quotient bit per clock, W clocks per
// division. A go while running is ignored. valid pulses once when the
// quotient is ready; the quotient then holds until the next go.
module cal_volt_udiv #(
    parameter int W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quotient,
    output logic         valid
);
    localparam int CNT_W = $clog2(W + 1);

    logic [W-1:0]     rem_q;
    logic [W-1:0]     dvs_q;
    logic [CNT_W-1:0] cnt_q;
    logic             run_q;
    logic [W:0]       shifted;
    logic [W:0]       trial;
    logic             fits;

    assign shifted = {rem_q, quotient[W-1]};
    assign trial   = shifted - {1'b0, dvs_q};
    assign fits    = ~trial[W];

    // Load operands on go, then shift-subtract one bit per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q    <= '0;
            dvs_q    <= '0;
            quotient <= '0;
            cnt_q    <= '0;
            run_q    <= 1'b0;
            valid    <= 1'b0;
        end else begin
            valid <= 1'b0;
            if (go && !run_q) begin
                quotient <= dividend;
                dvs_q    <= divisor;
                rem_q    <= '0;
                cnt_q    <= CNT_W'(W);
                run_q    <= 1'b1;
            end else if (run_q) begin
                rem_q    <= fits ? trial[W-1:0] : shifted[W-1:0];
                quotient <= {quotient[W-2:0], fits};
                cnt_q    <= cnt_q - CNT_W'(1);
                if (cnt_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    valid <= 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/cal_volt_conv.sv
`timescale 1ns/1ps
// Calibrated two-point voltage converter. Latches a request, computes
// the signed interpolation on a shared restoring divider, clamps, and
// optionally rescales by a rounded ratio on the same divider.
// Assumes PROD_W is wide enough for v * ratio_den (48 bits covers it).
module cal_volt_conv
    import cal_volt_pkg::*;
#(
    parameter int CODE_W  = 12,
    parameter int RATIO_W = 16,
    parameter int PROD_W  = 48
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CODE_W-1:0]  raw_code,
    input  logic               big_range,
    input  logic               alt_table,
    input  logic [CAL_W-1:0]   cal_word,
    input  logic               ratio_en,
    input  logic [RATIO_W-1:0] ratio_num,
    input  logic [RATIO_W-1:0] ratio_den,
    output logic [PROD_W-1:0]  volt_mv,
    output logic               done,
    output logic               err
);
    conv_state_t        state;
    logic [CODE_W-1:0]  raw_q;
    logic               big_q, alt_q, ren_q, neg_q;
    logic [CAL_W-1:0]   cal_q;
    logic [RATIO_W-1:0] num_q, den_q;

    logic signed [PT_W-1:0]   c0, c1, mv0, mv1, raw_s, diff_raw, span;
    logic signed [PROD_W-1:0] prod, den_w, q_s, v_s;
    logic [PROD_W-1:0]        prod_mag, den_mag, v_clamp, ratio_dvd;
    logic [PROD_W-1:0]        div_a, div_b, div_quo;
    logic                     div_go, div_valid, busy_w;

    cal_volt_points u_pts (
        .big_range (big_q),
        .alt_table (alt_q),
        .cal_word  (cal_q),
        .code0     (c0),
        .code1     (c1),
        .mv0       (mv0),
        .mv1       (mv1)
    );

    cal_volt_udiv #(.W(PROD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (div_go),
        .dividend (div_a),
        .divisor  (div_b),
        .quotient (div_quo),
        .valid    (div_valid)
    );

    assign busy_w   = (state != ST_IDLE);
    assign raw_s    = $signed({{(PT_W-CODE_W){1'b0}}, raw_q});
    assign diff_raw = raw_s - c1;
    assign span     = mv0 - mv1;
    assign prod     = PROD_W'(span) * PROD_W'(diff_raw);
    assign den_w    = PROD_W'(c0 - c1);
    assign prod_mag = prod[PROD_W-1]  ? $unsigned(-prod)  : $unsigned(prod);
    assign den_mag  = den_w[PROD_W-1] ? $unsigned(-den_w) : $unsigned(den_w);

    // Restore the sign of the quotient, add the base voltage, clamp at zero
    assign q_s       = neg_q ? -$signed(div_quo) : $signed(div_quo);
    assign v_s       = q_s + PROD_W'(mv1);
    assign v_clamp   = v_s[PROD_W-1] ? '0 : $unsigned(v_s);
    assign ratio_dvd = v_clamp * PROD_W'(den_q) + PROD_W'(num_q >> 1);

    // Choose divider operands and launch for each division phase
    always_comb begin
        div_go = 1'b0;
        div_a  = prod_mag;
        div_b  = den_mag;
        if (state == ST_PREP && den_w != '0)
            div_go = 1'b1;
        if (state == ST_INTERP && div_valid && ren_q && num_q != '0) begin
            div_go = 1'b1;
            div_a  = ratio_dvd;
            div_b  = PROD_W'(num_q);
        end
    end

    // Sequence the conversion and register the result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            raw_q   <= '0;
            big_q   <= 1'b0;
            alt_q   <= 1'b0;
            cal_q   <= '0;
            ren_q   <= 1'b0;
            num_q   <= '0;
            den_q   <= '0;
            neg_q   <= 1'b0;
            volt_mv <= '0;
            done    <= 1'b0;
            err     <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (start) begin
                    raw_q <= raw_code;
                    big_q <= big_range;
                    alt_q <= alt_table;
                    cal_q <= cal_word;
                    ren_q <= ratio_en;
                    num_q <= ratio_num;
                    den_q <= ratio_den;
                    state <= ST_PREP;
                end
                ST_PREP: begin
                    if (den_w == '0) begin
                        volt_mv <= '0;
                        err     <= 1'b1;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        neg_q <= prod[PROD_W-1] ^ den_w[PROD_W-1];
                        state <= ST_INTERP;
                    end
                end
                ST_INTERP: if (div_valid) begin
                    if (!ren_q) begin
                        volt_mv <= v_clamp;
                        err     <= 1'b0;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end else if (num_q == '0) begin
                        volt_mv <= '0;
                        err     <= 1'b1;
                        done    <= 1'b1;
                        state   <= ST_IDLE;
                    end else begin
                        state <= ST_RATIO;
                    end
                end
                ST_RATIO: if (div_valid) begin
                    volt_mv <= div_quo;
                    err     <= 1'b0;
                    done    <= 1'b1;
                    state   <= ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/cal_volt_conv_chk.sv
`timescale 1ns/1ps
// Protocol checks for the converter's strobe, result hold and accept rules.
module cal_volt_conv_chk #(
    parameter int W = 48
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         busy,
    input logic         done,
    input logic         err,
    input logic [W-1:0] volt
);
    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(volt) && $stable(err)));

    // R7
    err_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (volt == '0));

    // R10
    accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R10
    done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
endmodule

bind cal_volt_conv cal_volt_conv_chk #(.W(PROD_W)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .busy  (busy_w),
    .done  (done),
    .err   (err),
    .volt  (volt_mv)
);

// File: tb/cal_volt_conv_bench.sv
`timescale 1ns/1ps
module cal_volt_conv_bench;
    localparam int CODE_W  = 12;
    localparam int RATIO_W = 16;
    localparam int PROD_W  = 48;

    logic               clk = 1'b0;
    logic               rst_n;
    logic               start;
    logic [CODE_W-1:0]  raw_code;
    logic               big_range, alt_table, ratio_en;
    logic [15:0]        cal_word;
    logic [RATIO_W-1:0] ratio_num, ratio_den;
    logic [PROD_W-1:0]  volt_mv;
    logic               done, err;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    always #2.5 clk = ~clk;

    cal_volt_conv #(.CODE_W(CODE_W), .RATIO_W(RATIO_W), .PROD_W(PROD_W)) u_cal_volt_conv (
        .clk(clk), .rst_n(rst_n), .start(start), .raw_code(raw_code),
        .big_range(big_range), .alt_table(alt_table), .cal_word(cal_word),
        .ratio_en(ratio_en), .ratio_num(ratio_num), .ratio_den(ratio_den),
        .volt_mv(volt_mv), .done(done), .err(err)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            fails++;
            $display("FAIL R9 watchdog: actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    // Arithmetic reference built from the requirements
    function automatic void model(input int raw, input bit big, input bit alt, input int cal,
                                  input bit ren, input int rn, input int rd,
                                  output longint v, output bit e);
        int n0, n1, m0, m1, c0, c1;
        longint num, den;
        n0 = big ? (alt ? 850 : 856) : (alt ? 838 : 833);
        n1 = big ? (alt ? 728 : 733) : (alt ? 84 : 80);
        m0 = big ? 4200 : 1000;
        m1 = big ? 3600 : 100;
        c0 = ((cal & 255) + n0 - 128) * 4;
        c1 = (((cal >> 8) & 255) + n1 - 128) * 4;
        den = longint'(c0 - c1);
        e = 1'b0;
        if (den == 0) begin v = 0; e = 1'b1; return; end
        num = longint'(m0 - m1) * longint'(raw - c1);
        v = num / den + m1;
        if (v < 0) v = 0;
        if (ren) begin
            if (rn == 0) begin v = 0; e = 1'b1; return; end
            v = (v * rd + rn / 2) / rn;
        end
    endfunction

    task automatic expect_eq(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_conv(input string tag, input int raw, input bit big, input bit alt,
                           input int cal, input bit ren, input int rn, input int rd,
                           input longint ev, input bit ee);
        bit ok;
        @(negedge clk);
        raw_code = CODE_W'(raw); big_range = big; alt_table = alt; cal_word = 16'(cal);
        ratio_en = ren; ratio_num = RATIO_W'(rn); ratio_den = RATIO_W'(rd);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        ok = 1'b0;
        for (int i = 0; i < 400; i++) begin
            if (done) begin ok = 1'b1; break; end
            @(negedge clk);
        end
        if (!ok) begin
            checks++; fails++;
            $display("FAIL %s actual=timeout expected=done", tag);
            return;
        end
        expect_eq(tag, longint'(volt_mv), ev);
        expect_eq(tag, longint'(err), longint'(ee));
        @(negedge clk);
        expect_eq("R9", longint'(done), 0);
    endtask

    task automatic run_model(input string tag, input int raw, input bit big, input bit alt,
                             input int cal, input bit ren, input int rn, input int rd);
        longint ev;
        bit ee;
        model(raw, big, alt, cal, ren, rn, rd, ev, ee);
        do_conv(tag, raw, big, alt, cal, ren, rn, rd, ev, ee);
    endtask

    initial begin
        int cals [4];
        longint ev;
        bit ee;
        int dones;
        cals = '{32'h8080, 32'hFF00, 32'h00FF, 32'h7B00};
        rst_n = 1'b0; start = 1'b0; raw_code = '0; big_range = 1'b0; alt_table = 1'b0;
        cal_word = '0; ratio_en = 1'b0; ratio_num = '0; ratio_den = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset state
        expect_eq("R11", longint'(volt_mv), 0);
        expect_eq("R11", longint'(done), 0);
        expect_eq("R11", longint'(err), 0);

        // R1 byte mapping: code0 = (0x90+856-128)*4 = 3488 lands on 4200 mV
        do_conv("R1", 3488, 1'b1, 1'b0, 32'h7090, 1'b0, 1, 1, 4200, 1'b0);
        // R2 alternate tables at point 1
        do_conv("R2", 336, 1'b0, 1'b1, 32'h8080, 1'b0, 1, 1, 100, 1'b0);
        do_conv("R2", 2912, 1'b1, 1'b1, 32'h8080, 1'b0, 1, 1, 3600, 1'b0);
        // R4 negative result clamps to zero
        do_conv("R4", 0, 1'b0, 1'b0, 32'hFF80, 1'b0, 1, 1, 0, 1'b0);
        // R5 half rounds up, above-half rounds up
        do_conv("R5", 3488, 1'b1, 1'b0, 32'h7090, 1'b1, 16, 1, 263, 1'b0);
        do_conv("R5", 3488, 1'b1, 1'b0, 32'h7090, 1'b1, 9, 1, 467, 1'b0);
        // R6 equal ratio leaves value unchanged
        do_conv("R6", 3488, 1'b1, 1'b0, 32'h7090, 1'b1, 1, 1, 4200, 1'b0);
        do_conv("R6", 3488, 1'b1, 1'b0, 32'h7090, 1'b1, 5, 5, 4200, 1'b0);
        // R7 equal codes
        do_conv("R7", 2000, 1'b1, 1'b0, 32'h7B00, 1'b1, 1, 1, 0, 1'b1);
        // R8 zero numerator
        do_conv("R8", 3488, 1'b1, 1'b0, 32'h7090, 1'b1, 0, 7, 0, 1'b1);

        // R10 second start mid-conversion is ignored
        model(1000, 1'b0, 1'b0, 32'h8080, 1'b0, 1, 1, ev, ee);
        @(negedge clk);
        raw_code = 12'd1000; big_range = 1'b0; alt_table = 1'b0; cal_word = 16'h8080;
        ratio_en = 1'b0; ratio_num = 16'd1; ratio_den = 16'd1; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        raw_code = 12'd4000; big_range = 1'b1; ratio_en = 1'b1; ratio_num = 16'd3; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 400 && !done; i++) @(negedge clk);
        expect_eq("R10", longint'(volt_mv), ev);
        dones = 0;
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            if (done) dones++;
        end
        expect_eq("R10", dones, 0);

        // R3 sweep over ranges, tables, calibration words, ratios and codes
        for (int b = 0; b < 2; b++)
            for (int a = 0; a < 2; a++)
                for (int ci = 0; ci < 4; ci++)
                    for (int k = 0; k < 3; k++)
                        for (int r = 0; r < 16; r++) begin
                            if (k == 0)
                                run_model("R3", r * 273, b[0], a[0], cals[ci], 1'b0, 1, 1);
                            else if (k == 1)
                                run_model("R6", r * 273, b[0], a[0], cals[ci], 1'b1, 1, 1);
                            else
                                run_model("R5", r * 273, b[0], a[0], cals[ci], 1'b1, 48, 100);
                        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule